// File: doc/BRIEF.md
# Multiplexed-Bus Single-Word DMA Master

This block lets a network controller move one word at a time to or from a host I/O processor over a shared bus whose address and data share one set of lines. A receive event starts a write toward the host. A channel-attention pulse from the host starts a read from it. In both cases the block takes the bus through a hold-request / hold-acknowledge handshake. It then runs a four-phase bus cycle (T1 to T4) that stretches while the host keeps its ready line low, and it hands the bus back afterwards.

The interrupt line to the host is a sticky flag. A write transfer raises it and the next read transfer clears it. Events that arrive while a transfer is running are held as pending and served in arrival order. The tri-state AD bus appears as separate in, out and output-enable signals. The transfer address and the write word come in on input ports, which must stay stable from the event until the transfer ends. A read word is presented on a register together with a one-cycle valid pulse.

Top module: `mxbus_dma_master`

## Requirements
- R1: Reset is synchronous and may be held for any number of cycles. While it is active, and in the first cycle after an edge where it was sampled high, `irq_out`, `hold_req` and `ad_oe` are 0. Events that are pending at that moment are discarded.
- R2: `rx_evt` sampled high on edge E starts a write with no transfer running. After edge E+1 `irq_out` is 1 and `hold_req` is 0. After edge E+2 `hold_req` is 1.
- R3: `chan_attn` sampled high on edge E starts a read with no transfer running. After edge E+1 `irq_out` is 0 and `hold_req` is 0. After edge E+2 `hold_req` is 1.
- R4: While `hold_ack` is low, `hold_req` stays 1 and `ad_oe` stays 0 for any number of cycles.
- R5: After the edge that samples `hold_ack` high, `ad_oe` is 1 and `ad_out` equals `xfer_addr` for exactly one cycle (address phase). In the following cycle (T1) `ad_oe` is 0.
- R6: On a write, `ad_oe` is 1 and `ad_out` equals `wr_data` for exactly one cycle (T2), two cycles after the address phase. `ad_oe` is 0 from T3 onward.
- R7: The block stays in T3 for as long as `ready_in` is sampled low, with `hold_req` at 1. It enters T4 after the edge that samples `ready_in` high.
- R8: On a read, `ad_in` is captured into `rd_data` on the edge that samples `ready_in` high in T3. `rd_valid` is 1 for exactly the next cycle.
- R9: `hold_req` falls in the cycle after T4. No new transfer starts until `hold_ack` has been sampled low.
- R10: Events that arrive during a transfer are kept pending and served in arrival order. A write and a read that arrive in the same cycle are served write first.
- R11: `ad_oe` is 0 throughout T1 to T4 of a read, when the host owns the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | 1 | Receive event pulse; requests a write to the host |
| chan_attn | input | 1 | Channel-attention pulse from host; requests a read |
| hold_ack | input | 1 | Bus grant from host |
| ready_in | input | 1 | Host ready; low inserts wait states in T3 |
| ad_in | input | DW | AD bus value seen at the pins |
| xfer_addr | input | DW | Address placed on the bus in the address phase |
| wr_data | input | DW | Word driven in T2 of a write |
| irq_out | output | 1 | Interrupt to host (sticky, set by write, cleared by read) |
| hold_req | output | 1 | Bus request to host |
| ad_out | output | DW | Value driven onto the AD bus |
| ad_oe | output | 1 | AD bus output enable |
| rd_data | output | DW | Word captured on a read |
| rd_valid | output | 1 | One-cycle pulse marking new `rd_data` |

## Verification
The hardest state to reach is one where a write and a read are both pending with a specific age order. Only the irq level at each later hold rise reveals which one was served. The stimulus gets there by keeping `hold_ack` low so the block sits in the request phase while events are pulsed. It does this once with the read clearly older and once with both pulses in the same cycle. A further case keeps the grant high after the release while an event is pending, to show that the next request waits for the grant to drop.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_NOTE = 4'd1,
    S_REQ  = 4'd2,
    S_ADDR = 4'd3,
    S_T1   = 4'd4,
    S_T2   = 4'd5,
    S_T3   = 4'd6,
    S_T4   = 4'd7,
    S_REL  = 4'd8
  } bus_state_t;
endpackage

// File: rtl/mxbus_evt_queue.sv
module mxbus_evt_queue (
  input  logic clk,
  input  logic rst,
  input  logic wr_evt,
  input  logic rd_evt,
  input  logic pop,
  output logic head_valid,
  output logic head_is_rd
);
  logic pend_wr, pend_rd, rd_older;
  logic wr_keep, rd_keep, set_wr, set_rd;

  assign head_valid = pend_wr | pend_rd;
  assign head_is_rd = pend_rd & (~pend_wr | rd_older);

  always_comb begin
    wr_keep = pend_wr & ~(pop & ~head_is_rd);
    rd_keep = pend_rd & ~(pop & head_is_rd);
    set_wr  = wr_evt & ~wr_keep;
    set_rd  = rd_evt & ~rd_keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_wr  <= 1'b0;
      pend_rd  <= 1'b0;
      rd_older <= 1'b0;
    end else begin
      pend_wr <= wr_keep | set_wr;
      pend_rd <= rd_keep | set_rd;
      if (rd_keep && set_wr)      rd_older <= 1'b1;
      else if (wr_keep && set_rd) rd_older <= 1'b0;
      else if (set_wr && set_rd)  rd_older <= 1'b0;
    end
  end

  assert_pop_valid_R10: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
endmodule

// File: rtl/mxbus_cycle_fsm.sv
module mxbus_cycle_fsm
  import mxbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic head_valid,
  input  logic head_is_rd,
  input  logic hold_ack,
  input  logic ready_in,
  output logic pop,
  output logic irq_out,
  output logic hold_req,
  output logic drive_addr_n,
  output logic drive_data_n,
  output logic capture,
  output logic rd_phase
);
  bus_state_t st, st_n;
  logic kind_rd;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE: if (head_valid) st_n = S_NOTE;
      S_NOTE: st_n = S_REQ;
      S_REQ:  if (hold_ack) st_n = S_ADDR;
      S_ADDR: st_n = S_T1;
      S_T1:   st_n = S_T2;
      S_T2:   st_n = S_T3;
      S_T3:   if (ready_in) st_n = S_T4;
      S_T4:   st_n = S_REL;
      S_REL:  if (!hold_ack) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign pop          = (st == S_IDLE) && head_valid;
  assign drive_addr_n = (st_n == S_ADDR);
  assign drive_data_n = (st_n == S_T2) && !kind_rd;
  assign capture      = (st == S_T3) && ready_in && kind_rd;
  assign rd_phase     = kind_rd && (st == S_T1 || st == S_T2 || st == S_T3 || st == S_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      kind_rd  <= 1'b0;
      irq_out  <= 1'b0;
      hold_req <= 1'b0;
    end else begin
      st       <= st_n;
      hold_req <= (st_n == S_REQ) || (st_n == S_ADDR) || (st_n == S_T1) ||
                  (st_n == S_T2) || (st_n == S_T3) || (st_n == S_T4);
      if (pop) begin
        kind_rd <= head_is_rd;
        irq_out <= !head_is_rd;
      end
    end
  end

  assert_hold_after_note_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_req) |-> $past(st) == S_NOTE);
  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_REQ && !hold_ack) |=> (st == S_REQ && hold_req));
  assert_wait_state_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_T3 && !ready_in) |=> (st == S_T3 && hold_req));
  assert_t4_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_T3 && ready_in) |=> (st == S_T4));
  assert_release_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_REL && hold_ack) |=> (st == S_REL && !hold_req));
endmodule

// File: rtl/mxbus_ad_path.sv
module mxbus_ad_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drive_addr_n,
  input  logic          drive_data_n,
  input  logic          capture,
  input  logic          rd_phase,
  input  logic          hold_req,
  input  logic [DW-1:0] xfer_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ad_oe    <= drive_addr_n | drive_data_n;
      ad_out   <= drive_addr_n ? xfer_addr : (drive_data_n ? wr_data : '0);
      rd_valid <= capture;
      if (capture) rd_data <= ad_in;
    end
  end

  assert_oe_needs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> hold_req);
  assert_rd_no_drive_R11: assert property (@(posedge clk) disable iff (rst)
    rd_phase |-> !ad_oe);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/mxbus_dma_master.sv
module mxbus_dma_master #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_evt,
  input  logic          chan_attn,
  input  logic          hold_ack,
  input  logic          ready_in,
  input  logic [DW-1:0] ad_in,
  input  logic [DW-1:0] xfer_addr,
  input  logic [DW-1:0] wr_data,
  output logic          irq_out,
  output logic          hold_req,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic head_valid, head_is_rd, pop;
  logic drive_addr_n, drive_data_n, capture, rd_phase;

  mxbus_evt_queue u_queue (
    .clk(clk), .rst(rst), .wr_evt(rx_evt), .rd_evt(chan_attn), .pop(pop),
    .head_valid(head_valid), .head_is_rd(head_is_rd)
  );

  mxbus_cycle_fsm u_fsm (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_is_rd(head_is_rd),
    .hold_ack(hold_ack), .ready_in(ready_in), .pop(pop), .irq_out(irq_out),
    .hold_req(hold_req), .drive_addr_n(drive_addr_n), .drive_data_n(drive_data_n),
    .capture(capture), .rd_phase(rd_phase)
  );

  mxbus_ad_path #(.DW(DW)) u_ad (
    .clk(clk), .rst(rst), .drive_addr_n(drive_addr_n), .drive_data_n(drive_data_n),
    .capture(capture), .rd_phase(rd_phase), .hold_req(hold_req),
    .xfer_addr(xfer_addr), .wr_data(wr_data), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!hold_req && !irq_out && !ad_oe));
endmodule

// File: tb/mxbus_dma_master_tb_top.sv
module mxbus_dma_master_tb_top;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_evt = 1'b0, chan_attn = 1'b0, hold_ack = 1'b0, ready_in = 1'b0;
  logic [DW-1:0] ad_in = '0, xfer_addr = 16'hC350, wr_data = 16'h0FA0;
  logic irq_out, hold_req, ad_oe, rd_valid;
  logic [DW-1:0] ad_out, rd_data;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mxbus_dma_master #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .rx_evt(rx_evt), .chan_attn(chan_attn),
    .hold_ack(hold_ack), .ready_in(ready_in), .ad_in(ad_in),
    .xfer_addr(xfer_addr), .wr_data(wr_data), .irq_out(irq_out),
    .hold_req(hold_req), .ad_out(ad_out), .ad_oe(ad_oe),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit wr, input bit rd);
    rx_evt = wr;
    chan_attn = rd;
    step();
    rx_evt = 1'b0;
    chan_attn = 1'b0;
  endtask

  // event pulse, then NOTE and REQ phases with exact timing
  task automatic launch(input bit is_rd);
    pulse(!is_rd, is_rd);
    step();
    chk(irq_out == !is_rd && !hold_req, is_rd ? "R3 irq cleared" : "R2 irq raised",
        {irq_out, hold_req}, {!is_rd, 1'b0});
    step();
    chk(hold_req, is_rd ? "R3 hold one cycle later" : "R2 hold one cycle later",
        hold_req, 1);
  endtask

  task automatic wait_hold(input bit exp_irq, input string tag);
    int n = 0;
    while (!hold_req && n < 12) begin
      step();
      n++;
    end
    chk(hold_req && irq_out == exp_irq, tag, {hold_req, irq_out}, {1'b1, exp_irq});
  endtask

  // from REQ state: grant, run T1..T4, release
  task automatic bus_cycle(input bit is_rd, input int waits, input logic [DW-1:0] rv,
                           input int linger);
    hold_ack = 1'b1;
    step();
    chk(ad_oe && ad_out == xfer_addr, "R5 address phase", {ad_oe, ad_out}, {1'b1, xfer_addr});
    step();
    chk(!ad_oe, "R5 release after address", ad_oe, 0);
    step();
    if (is_rd) chk(!ad_oe, "R11 no drive in T2 of read", ad_oe, 0);
    else chk(ad_oe && ad_out == wr_data, "R6 write data in T2", {ad_oe, ad_out}, {1'b1, wr_data});
    step();
    chk(!ad_oe, is_rd ? "R11 no drive in T3" : "R6 drive stops after T2", ad_oe, 0);
    for (int i = 0; i < waits; i++) begin
      step();
      chk(hold_req && !ad_oe && !rd_valid, "R7 wait state", {hold_req, ad_oe}, 2'b10);
    end
    ready_in = 1'b1;
    if (is_rd) ad_in = rv;
    step();
    chk(hold_req, "R7 T4 keeps hold", hold_req, 1);
    if (is_rd) chk(rd_valid && rd_data == rv, "R8 read capture", {rd_valid, rd_data}, {1'b1, rv});
    ready_in = 1'b0;
    ad_in = '0;
    step();
    chk(!hold_req, "R9 hold drops after T4", hold_req, 0);
    if (is_rd) chk(!rd_valid && rd_data == rv, "R8 valid one cycle", rd_valid, 0);
    for (int i = 0; i < linger; i++) begin
      step();
      chk(!hold_req && !irq_out == is_rd, "R9 no new request while granted",
          hold_req, 0);
    end
    hold_ack = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) step();
    chk(!irq_out && !hold_req && !ad_oe, "R1 outputs quiet in reset",
        {irq_out, hold_req, ad_oe}, 0);
    rst = 1'b0;
    step();
    chk(!hold_req && !ad_oe, "R1 idle after reset", {hold_req, ad_oe}, 0);
  endtask

  task automatic t_write();
    launch(1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(hold_req && !ad_oe, "R4 hold kept while not granted", {hold_req, ad_oe}, 2'b10);
    end
    bus_cycle(1'b0, 2, '0, 0);
  endtask

  task automatic t_read();
    launch(1'b1);
    step();
    bus_cycle(1'b1, 3, 16'hA55A, 0);
  endtask

  task automatic t_order_arrival();
    launch(1'b0);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    bus_cycle(1'b0, 0, '0, 0);
    wait_hold(1'b0, "R10 older read served first");
    bus_cycle(1'b1, 1, 16'h1234, 0);
    wait_hold(1'b1, "R10 younger write served second");
    bus_cycle(1'b0, 0, '0, 0);
  endtask

  task automatic t_order_tie();
    launch(1'b1);
    pulse(1'b1, 1'b1);
    bus_cycle(1'b1, 0, 16'h00FF, 0);
    wait_hold(1'b1, "R10 tie serves write first");
    bus_cycle(1'b0, 1, '0, 0);
    wait_hold(1'b0, "R10 tie serves read second");
    bus_cycle(1'b1, 0, 16'hBEEF, 0);
  endtask

  task automatic t_linger();
    launch(1'b0);
    pulse(1'b0, 1'b1);
    bus_cycle(1'b0, 0, '0, 3);
    wait_hold(1'b0, "R9 pending read starts after grant drops");
    bus_cycle(1'b1, 0, 16'h7777, 0);
  endtask

  task automatic t_mid_reset();
    launch(1'b0);
    pulse(1'b0, 1'b1);
    rst = 1'b1;
    step();
    chk(!irq_out && !hold_req && !ad_oe, "R1 reset during request",
        {irq_out, hold_req, ad_oe}, 0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(!hold_req && !irq_out, "R1 pending discarded by reset", {hold_req, irq_out}, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_order_arrival();
    t_order_tie();
    t_linger();
    t_mid_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule